// File: doc/BRIEF.md
# Sub-Word Load/Store Lane Merger

This block sits in front of a small data memory organised as 8-byte rows. It accepts load and store requests of 1, 2, 4 or 8 bytes at a byte address. It splits the address into a row index (the address shifted right by three) and a byte offset (the three low bits). Data is placed in, or taken from, the byte lanes that start at bit `offset*8`. No endian mirroring is applied.

A store narrower than a row is a two-cycle read-modify-write. The first cycle reads the old row. The second cycle writes back the old row with the addressed lanes replaced. A full-row store skips the read and writes in one cycle.

Each request can ask for the bytes to be reversed within the access width. A store reverses before lane placement, and a load reverses after extraction. A per-row valid bitmap, cleared by reset, marks which rows have been written. An unwritten row reads as zero. A probe load also reports that row as absent. A request whose offset is not a multiple of its width is rejected with an error and changes no memory.

Top module: `subword_lane_merge`

## Requirements
- R1: A load of size code `s` (0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes) at byte address `a` returns, right-justified, the `2^s` bytes of row `a>>3` starting at bit `(a&7)*8`.
- R2: A request whose offset `a&7` is not a multiple of its width gives `rsp_err`=1 with `rsp_rdata`=0 one cycle later, and leaves memory unchanged.
- R3: A narrow store (size code 0, 1 or 2) replaces only the addressed lanes of the row. All other lanes keep their previous contents, or zero if the row was unwritten.
- R4: A full-row store (size code 3) writes the whole row in one cycle. `busy` stays low and `rsp_valid` rises one cycle after acceptance.
- R5: A non-probe load of a row never written returns zero with `rsp_absent`=0.
- R6: A probe load (`req_probe`=1) of an unwritten row gives `rsp_absent`=1 with zero data. A probe load of a written row gives `rsp_absent`=0 with normal data.
- R7: With `req_swap`=1, the byte order within the access width is reversed: on a store before lane placement, on a load after extraction.
- R8: An aligned narrow store holds `busy` high for exactly one cycle after acceptance, and `rsp_valid` follows one cycle later. A request presented while `busy` is high is ignored.
- R9: An accepted load gives `rsp_valid` exactly one cycle later. Data bits above the access width are zero.
- R10: Reset clears the valid bitmap, `busy` and `rsp_valid`. After reset every row probes as absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; accepted when busy is low |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Width code: 0=1B, 1=2B, 2=4B, 3=8B |
| req_swap | input | 1 | Reverse bytes within the access width |
| req_probe | input | 1 | Load reports absent rows instead of plain zero |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Store data, right-justified |
| busy | output | 1 | Read-modify-write in progress; requests ignored |
| rsp_valid | output | 1 | Response for the accepted request |
| rsp_err | output | 1 | Request was misaligned |
| rsp_absent | output | 1 | Probe load hit an unwritten row |
| rsp_rdata | output | 64 | Load data, right-justified |

## Verification
The bound checker watches the handshake timing on every cycle. It checks the one-cycle load and full-store latency and the single `busy` cycle of a narrow store. It also checks that a misaligned request answers with an error and zero data, that `rsp_absent` appears only after a probe load, and that a byte load has zero upper bits. Lane placement, merging with the old row, byte reversal, and the fact that a rejected or ignored request changes nothing can only be shown by the bench. The bench reads the data back and compares it with a reference memory model, under directed and seeded random sequences.

// File: rtl/subword_lane_merge.sv
module subword_lane_merge #(
  parameter int ROWS = 32,
  localparam int ROW_W = 64,
  localparam int OFF_W = 3,
  localparam int IDX_W = $clog2(ROWS),
  localparam int ADDR_W = IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic              req_swap,
  input  logic              req_probe,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ROW_W-1:0]  req_wdata,
  output logic              busy,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic              rsp_absent,
  output logic [ROW_W-1:0]  rsp_rdata
);

  function automatic logic [ROW_W-1:0] lane_mask(input logic [1:0] sz);
    logic [ROW_W-1:0] m;
    m = '0;
    for (int b = 0; b < 8; b++)
      if (b < (1 << sz)) m[8*b +: 8] = 8'hFF;
    return m;
  endfunction

  function automatic logic [ROW_W-1:0] swap_bytes(input logic [ROW_W-1:0] d,
                                                  input logic [1:0] sz);
    logic [ROW_W-1:0] r;
    int nb;
    nb = 1 << sz;
    r = '0;
    for (int b = 0; b < 8; b++)
      if (b < nb) r[8*b +: 8] = d[8*(nb-1-b) +: 8];
    return r;
  endfunction

  logic [ROW_W-1:0] mem [ROWS];
  logic [ROWS-1:0]  vld;

  logic [IDX_W-1:0] st_idx;
  logic [ROW_W-1:0] st_data, st_mask, old_q;

  wire              acc   = req_valid && !busy;
  wire [IDX_W-1:0]  idx   = req_addr[ADDR_W-1:OFF_W];
  wire [OFF_W-1:0]  off   = req_addr[OFF_W-1:0];
  wire [5:0]        shamt = {off, 3'b000};
  wire [3:0]        nbytes = 4'd1 << req_size;
  wire              misal = (({1'b0, off} & (nbytes - 4'd1)) != 4'd0);
  wire              full  = (req_size == 2'd3);

  wire [ROW_W-1:0]  msk    = lane_mask(req_size);
  wire [ROW_W-1:0]  row_rd = vld[idx] ? mem[idx] : '0;
  wire [ROW_W-1:0]  ext    = (row_rd >> shamt) & msk;
  wire [ROW_W-1:0]  ldata  = req_swap ? swap_bytes(ext, req_size) : ext;
  wire [ROW_W-1:0]  wsrc   = req_wdata & msk;
  wire [ROW_W-1:0]  wplace = (req_swap ? swap_bytes(wsrc, req_size) : wsrc) << shamt;
  wire [ROW_W-1:0]  wmask  = msk << shamt;

  always_ff @(posedge clk) begin
    if (busy) begin
      mem[st_idx] <= (old_q & ~st_mask) | (st_data & st_mask);
    end else if (acc && req_write && !misal) begin
      if (full) begin
        mem[idx] <= wplace;
      end else begin
        st_idx  <= idx;
        st_data <= wplace;
        st_mask <= wmask;
        old_q   <= row_rd;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld        <= '0;
      busy       <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_absent <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_absent <= 1'b0;
      if (busy) begin
        busy        <= 1'b0;
        vld[st_idx] <= 1'b1;
        rsp_valid   <= 1'b1;
        rsp_rdata   <= '0;
      end else if (acc) begin
        rsp_rdata <= '0;
        if (misal) begin
          rsp_valid <= 1'b1;
          rsp_err   <= 1'b1;
        end else if (req_write) begin
          if (full) begin
            vld[idx]  <= 1'b1;
            rsp_valid <= 1'b1;
          end else begin
            busy <= 1'b1;
          end
        end else begin
          rsp_valid  <= 1'b1;
          rsp_rdata  <= ldata;
          rsp_absent <= req_probe && !vld[idx];
        end
      end
    end
  end

endmodule

// File: rtl/subword_lane_merge_chk.sv
module subword_lane_merge_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [1:0]        req_size,
  input logic              req_probe,
  input logic [ADDR_W-1:0] req_addr,
  input logic              busy,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic              rsp_absent,
  input logic [63:0]       rsp_rdata
);

  logic take, bad;
  assign take = req_valid && !busy;
  always_comb begin
    case (req_size)
      2'd0: bad = 1'b0;
      2'd1: bad = req_addr[0];
      2'd2: bad = |req_addr[1:0];
      default: bad = |req_addr[2:0];
    endcase
  end

  p_misaligned_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take && bad |=> rsp_valid && rsp_err && rsp_rdata == 64'd0);

  p_full_store_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_write && !bad && req_size == 2'd3 |=> rsp_valid && !busy);

  p_absent_after_probe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take && !req_probe |=> !rsp_absent);

  p_absent_zero_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_absent |-> rsp_valid && !rsp_err && rsp_rdata == 64'd0);

  p_narrow_store_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_write && !bad && req_size != 2'd3 |=> busy && !rsp_valid);

  p_busy_single_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy && rsp_valid && !rsp_err);

  p_load_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take && !req_write |=> rsp_valid);

  p_byte_load_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take && !req_write && req_size == 2'd0 |=> rsp_rdata[63:8] == 56'd0);

endmodule

bind subword_lane_merge subword_lane_merge_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_subword_lane_merge.sv
module tb_subword_lane_merge;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 32;
  localparam int AW = $clog2(ROWS) + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_swap = 1'b0, req_probe = 1'b0;
  logic [1:0] req_size = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic busy, rsp_valid, rsp_err, rsp_absent;
  logic [63:0] rsp_rdata;

  int checks = 0, failures = 0;
  logic [63:0] ref_mem [ROWS];
  logic [ROWS-1:0] ref_vld;

  always #(CLK_PERIOD/2) clk = ~clk;

  subword_lane_merge #(.ROWS(ROWS)) dut (.*);

  function automatic logic [63:0] wmask(input int sz);
    int nb = 1 << sz;
    return (nb == 8) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8*nb)) - 64'd1);
  endfunction

  function automatic logic [63:0] rev(input logic [63:0] d, input int sz);
    logic [63:0] r = '0;
    for (int k = 0; k < (1 << sz); k++) r = (r << 8) | ((d >> (8*k)) & 64'hFF);
    return r;
  endfunction

  function automatic bit is_misal(input int sz, input logic [AW-1:0] a);
    return (int'(a[2:0]) % (1 << sz)) != 0;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input bit wr, input int sz, input bit sw, input bit pr,
                       input logic [AW-1:0] a, input logic [63:0] wd,
                       output logic [63:0] dat, output bit err, output bit abs, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = 2'(sz); req_swap = sw;
    req_probe = pr; req_addr = a; req_wdata = wd;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 4) begin
      @(posedge clk); @(negedge clk); lat++;
    end
    dat = rsp_rdata; err = rsp_err; abs = rsp_absent;
  endtask

  task automatic ref_op(input bit wr, input int sz, input bit sw, input bit pr,
                        input logic [AW-1:0] a, input logic [63:0] wd,
                        output logic [63:0] edat, output bit eerr, output bit eabs, output int elat);
    int row = int'(a >> 3);
    int sh = 8 * int'(a[2:0]);
    logic [63:0] m = wmask(sz);
    logic [63:0] cur = ref_vld[row] ? ref_mem[row] : 64'd0;
    logic [63:0] d;
    edat = '0; eerr = 0; eabs = 0; elat = 1;
    if (is_misal(sz, a)) begin
      eerr = 1;
    end else if (wr) begin
      d = sw ? rev(wd & m, sz) : (wd & m);
      ref_mem[row] = (cur & ~(m << sh)) | ((d << sh) & (m << sh));
      ref_vld[row] = 1'b1;
      elat = (sz == 3) ? 1 : 2;
    end else begin
      d = (cur >> sh) & m;
      edat = sw ? rev(d, sz) : d;
      eabs = pr && !ref_vld[row];
    end
  endtask

  task automatic run(input string req, input bit wr, input int sz, input bit sw, input bit pr,
                     input logic [AW-1:0] a, input logic [63:0] wd);
    logic [63:0] dat, edat; bit err, abs, eerr, eabs; int lat, elat;
    ref_op(wr, sz, sw, pr, a, wd, edat, eerr, eabs, elat);
    issue(wr, sz, sw, pr, a, wd, dat, err, abs, lat);
    check(lat == elat, {req, " latency"}, 64'(lat), 64'(elat));
    check(err == eerr, {req, " err"}, 64'(err), 64'(eerr));
    check(abs == eabs, {req, " absent"}, 64'(abs), 64'(eabs));
    if (!wr) check(dat == edat, {req, " data"}, dat, edat);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    ref_vld = '0;
    for (int i = 0; i < ROWS; i++) ref_mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    check(!busy && !rsp_valid, "R10 reset state", {62'd0, busy, rsp_valid}, 64'd0);

    run("R10 probe after reset", 0, 3, 0, 1, AW'(5*8), 0);
    run("R5 unwritten load", 0, 2, 0, 0, AW'(5*8+4), 0);
    run("R4 full store", 1, 3, 0, 0, AW'(5*8), 64'h1122_3344_5566_7788);
    run("R1 full load", 0, 3, 0, 0, AW'(5*8), 0);
    run("R8 narrow store", 1, 0, 0, 0, AW'(5*8+3), 64'hFFFF_FFAB);
    run("R3 merged row", 0, 3, 0, 0, AW'(5*8), 0);
    check(ref_mem[5] == 64'h1122_3344_AB66_7788, "R3 model lanes", ref_mem[5], 64'h1122_3344_AB66_7788);
    run("R1 half load", 0, 1, 0, 0, AW'(5*8+2), 0);
    run("R7 swap store", 1, 2, 1, 0, AW'(9*8+4), 64'h0102_0304);
    run("R7 plain readback", 0, 2, 0, 0, AW'(9*8+4), 0);
    run("R7 swapped readback", 0, 2, 1, 0, AW'(9*8+4), 0);
    run("R3 unwritten lanes zero", 0, 2, 0, 0, AW'(9*8), 0);
    run("R2 misaligned store", 1, 2, 0, 0, AW'(5*8+2), 64'hDEAD_BEEF);
    run("R2 row unchanged", 0, 3, 0, 0, AW'(5*8), 0);
    run("R2 misaligned load", 0, 3, 0, 0, AW'(5*8+1), 0);
    run("R6 probe written", 0, 3, 0, 1, AW'(9*8), 0);

    // R8: a request during busy is ignored
    @(negedge clk);
    req_valid = 1; req_write = 1; req_size = 2'd1; req_swap = 0; req_probe = 0;
    req_addr = AW'(12*8); req_wdata = 64'hBEEF;
    @(posedge clk); @(negedge clk);
    check(busy == 1'b1, "R8 busy after narrow store", {63'd0, busy}, 64'd1);
    req_write = 1; req_size = 2'd3; req_addr = AW'(12*8); req_wdata = 64'hFFFF_FFFF_FFFF_FFFF;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    check(rsp_valid && !busy, "R8 store response", {62'd0, rsp_valid, busy}, 64'd2);
    @(posedge clk); @(negedge clk);
    check(!rsp_valid, "R8 ignored request no response", {63'd0, rsp_valid}, 64'd0);
    ref_mem[12] = 64'hBEEF; ref_vld[12] = 1;
    run("R8 ignored store left row", 0, 3, 0, 0, AW'(12*8), 0);

    for (int n = 0; n < 500; n++) begin
      automatic int sz = int'($urandom(0) % 4);
      automatic logic [AW-1:0] a;
      if (n == 0) void'($urandom(32'h5EED));
      sz = int'($urandom % 4);
      a = AW'((($urandom % 8) + 16) * 8);
      if ($urandom % 8 == 0) a[2:0] = 3'($urandom);
      else a[2:0] = 3'((($urandom % 8) >> sz) << sz);
      run(($urandom % 2) ? "R3 random" : "R1 random",
          bit'($urandom % 2), sz, bit'($urandom % 2), bit'($urandom % 2),
          a, {$urandom, $urandom});
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule